// File: doc/BRIEF.md
# Three-Wire Control Bus Slave

This block lets a host controller load a bank of 35 eight-bit coefficients over a three-wire serial control bus. The bus has an ident line, a clock line and a shared open-drain data line. All three rest high when idle. A transfer opens with ident going low, carries an eight-bit address, and switches to the data phase when ident returns high. Eight or sixteen data bits follow, and the transfer closes with a brief low pulse on ident. Every bit travels least significant first and is taken on the rising edge of the bus clock. The two bus strobes and the data line are synchronised to the system clock, and their edges are detected inside the block.

The device does not answer to an address of its own. A shared select address (102) takes a select byte. Only after the byte 15 has been written there does the block accept coefficient writes or answer reads. Coefficient writes take effect only at the closing ident pulse, and only if the number of data bits matches the length that the address calls for. A read-out port lets the surrounding datapath fetch any coefficient by index at any time.

Top module: `cbus_slave`

## Requirements
- R1: After reset, every coefficient is 0x00 except entry 33, which is 0x08. The device is deselected and the data line is released (cb_data_pull low).
- R2: While ident is low, bits are shifted into the address least significant first, one on each rising bus-clock edge. Ident rising ends the address phase. If the address phase did not hold exactly 8 bits, the transfer is abandoned.
- R3: Data bits arrive least significant first, one per rising bus-clock edge. A write commits only at the falling ident edge of the closing pulse, and only if the bit count equals 16 for address 100 or 8 for any other address. Otherwise the transfer is discarded.
- R4: An 8-bit write of 15 to address 102 selects the device. An 8-bit write of any other value to address 102 deselects it.
- R5: While the device is deselected, writes to addresses 64..98 and 100 leave all coefficients unchanged.
- R6: An 8-bit write to address 64+i, with i in 0..34, stores the byte in coefficient i.
- R7: A 16-bit write to address 100 stores the low byte in coefficient 0 and the high byte in coefficient 1, in the same cycle.
- R8: Writes to any other address (including 63, 99, 101 and 103 and above) change no coefficient.
- R9: While the device is selected, a read at address 128+i, with i in 0..34, returns coefficient i least significant first. Each bit is presented after a falling bus-clock edge by pulling the line low for a 0. In all other cases the host reads all ones.
- R10: A transfer may pause for any length of time between bus-clock edges without being aborted.
- R11: coef_q shows the coefficient selected by coef_idx combinationally, and reads 0 for an index of 35 or more.
- R12: cb_data_pull is high only during the data phase of a read that the device is answering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cb_ident | input | 1 | Bus ident line, asynchronous |
| cb_clk | input | 1 | Bus clock line, asynchronous |
| cb_data | input | 1 | Level sensed on the shared data line |
| cb_data_pull | output | 1 | High to pull the shared data line low |
| coef_idx | input | 6 | Coefficient index for the read-out port |
| coef_q | output | 8 | Coefficient value at coef_idx |

## Verification
The bench builds the block with its default parameters: 35 coefficients, two synchroniser stages, select word 15 at address 102, read base 128. It clocks the bus at 16 system cycles per bit, which leaves room for the synchroniser delay before each sample. These values let it sweep every coefficient address for writes, bus reads and read-out, and also try the neighbouring unmapped addresses, short and long bit counts, a truncated address phase and a long stall. The select handshake is driven through select, wrong select and deselect sequences, and a bench-side model of the coefficient bank is compared after every step.

// File: rtl/cbus_pkg.sv
package cbus_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2,
    PH_TAIL = 2'd3
  } phase_e;
endpackage

// File: rtl/cbus_sync.sv
// Multi-stage synchroniser with edge detection for a group of lines.
module cbus_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  output logic [N-1:0] level,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] stg_q [STAGES];
  logic [N-1:0] prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [N-1:0] stg_n;
    if (g == 0) begin : g_first
      assign stg_n = raw;
    end else begin : g_next
      assign stg_n = stg_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[g] <= '1;
      else        stg_q[g] <= stg_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= stg_q[STAGES-1];
  end

  assign level = stg_q[STAGES-1];
  assign rise  = stg_q[STAGES-1] & ~prev_q;
  assign fall  = ~stg_q[STAGES-1] & prev_q;
endmodule

// File: rtl/cbus_frame.sv
// Transfer framing: address phase, data phase, closing pulse.
module cbus_frame
  import cbus_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int CW = $clog2(DW + 1) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          id_fall,
  input  logic          id_rise,
  input  logic          ck_rise,
  input  logic          din,
  output phase_e        phase,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] data,
  output logic [CW-1:0] cnt,
  output logic          addr_done,
  output logic          end_evt
);
  phase_e        phase_q, phase_n;
  logic [AW-1:0] addr_q, addr_n;
  logic [DW-1:0] data_q, data_n;
  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    phase_n   = phase_q;
    addr_n    = addr_q;
    data_n    = data_q;
    cnt_n     = cnt_q;
    addr_done = 1'b0;
    end_evt   = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (id_fall) begin
          phase_n = PH_ADDR;
          cnt_n   = '0;
          addr_n  = '0;
        end
      end
      PH_ADDR: begin
        if (id_rise) begin
          if (cnt_q == CW'(AW)) begin
            phase_n   = PH_DATA;
            addr_done = 1'b1;
            cnt_n     = '0;
            data_n    = '0;
          end else begin
            phase_n = PH_IDLE;
          end
        end else if (ck_rise) begin
          for (int i = 0; i < AW; i++)
            if (cnt_q == CW'(i)) addr_n[i] = din;
          if (cnt_q != '1) cnt_n = cnt_q + CW'(1);
        end
      end
      PH_DATA: begin
        if (id_fall) begin
          phase_n = PH_TAIL;
          end_evt = 1'b1;
        end else if (ck_rise) begin
          for (int i = 0; i < DW; i++)
            if (cnt_q == CW'(i)) data_n[i] = din;
          if (cnt_q != '1) cnt_n = cnt_q + CW'(1);
        end
      end
      default: begin
        if (id_rise) phase_n = PH_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_n;
      addr_q  <= addr_n;
      data_q  <= data_n;
      cnt_q   <= cnt_n;
    end
  end

  assign phase = phase_q;
  assign addr  = addr_q;
  assign data  = data_q;
  assign cnt   = cnt_q;
endmodule

// File: rtl/cbus_regfile.sv
// Coefficient bank: two write ports (b wins), two read ports.
module cbus_regfile #(
  parameter int N       = 35,
  parameter int W       = 8,
  parameter int RST_IDX = 33,
  parameter int RST_VAL = 8,
  parameter int IW      = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_a,
  input  logic [IW-1:0] ia,
  input  logic [W-1:0]  da,
  input  logic          we_b,
  input  logic [IW-1:0] ib,
  input  logic [W-1:0]  db,
  input  logic [IW-1:0] ra,
  output logic [W-1:0]  qa,
  input  logic [IW-1:0] rb,
  output logic [W-1:0]  qb
);
  logic [W-1:0] mem_q [N];

  for (genvar g = 0; g < N; g++) begin : g_ent
    localparam logic [W-1:0] RV = (g == RST_IDX) ? W'(RST_VAL) : '0;
    logic [W-1:0] ent_n;
    logic         ent_en;
    always_comb begin
      ent_en = 1'b0;
      ent_n  = mem_q[g];
      if (we_b && ib == IW'(g)) begin
        ent_en = 1'b1;
        ent_n  = db;
      end else if (we_a && ia == IW'(g)) begin
        ent_en = 1'b1;
        ent_n  = da;
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mem_q[g] <= RV;
      else if (ent_en) mem_q[g] <= ent_n;
    end
  end

  always_comb begin
    qa = '0;
    qb = '0;
    for (int i = 0; i < N; i++) begin
      if (ra == IW'(i)) qa = mem_q[i];
      if (rb == IW'(i)) qb = mem_q[i];
    end
  end
endmodule

// File: rtl/cbus_slave.sv
// Three-wire control bus slave with select handshake and coefficient bank.
module cbus_slave
  import cbus_pkg::*;
#(
  parameter int COEF_N      = 35,
  parameter int COEF_W      = 8,
  parameter int ADDR_W      = 8,
  parameter int COEF_BASE   = 64,
  parameter int SEL_ADDR    = 102,
  parameter int SEL_WORD    = 15,
  parameter int PAIR_ADDR   = 100,
  parameter int RD_BASE     = 128,
  parameter int CTRL_IDX    = 33,
  parameter int CTRL_RST    = 8,
  parameter int SYNC_STAGES = 2,
  parameter int IDX_W       = $clog2(COEF_N + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cb_ident,
  input  logic             cb_clk,
  input  logic             cb_data,
  output logic             cb_data_pull,
  input  logic [IDX_W-1:0] coef_idx,
  output logic [COEF_W-1:0] coef_q
);
  localparam int DATA_W = 2 * COEF_W;
  localparam int CNT_W  = $clog2(DATA_W + 1) + 1;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sh_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= '0;
    else        rst_sh_q <= {rst_sh_q[0], 1'b1};
  end
  assign rst_i_n = rst_sh_q[1];

  logic [2:0]        lv, rs, fl;
  phase_e            phase;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [CNT_W-1:0]  cnt;
  logic              addr_done, end_evt;
  logic              is_coef, is_pair, is_sel, is_rd, len_ok;
  logic              sel_q, sel_n;
  logic              we_a, we_b;
  logic [IDX_W-1:0]  ia, rd_idx;
  logic [COEF_W-1:0] rd_val;
  logic              rd_act_q, rd_act_n;
  logic              drv_q, drv_n;
  logic [COEF_W-1:0] rd_sh_q, rd_sh_n;
  int                a_int;

  cbus_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_i_n),
    .raw({cb_data, cb_clk, cb_ident}),
    .level(lv), .rise(rs), .fall(fl)
  );

  cbus_frame #(.AW(ADDR_W), .DW(DATA_W), .CW(CNT_W)) u_frame (
    .clk(clk), .rst_n(rst_i_n),
    .id_fall(fl[0]), .id_rise(rs[0]), .ck_rise(rs[1]), .din(lv[2]),
    .phase(phase), .addr(addr_q), .data(data_q), .cnt(cnt),
    .addr_done(addr_done), .end_evt(end_evt)
  );

  // address decode
  always_comb begin
    a_int   = int'(addr_q);
    is_coef = (a_int >= COEF_BASE) && (a_int < COEF_BASE + COEF_N);
    is_pair = (a_int == PAIR_ADDR);
    is_sel  = (a_int == SEL_ADDR);
    is_rd   = (a_int >= RD_BASE) && (a_int < RD_BASE + COEF_N);
    len_ok  = is_pair ? (cnt == CNT_W'(DATA_W)) : (cnt == CNT_W'(COEF_W));
    ia      = is_pair ? IDX_W'(0) : IDX_W'(a_int - COEF_BASE);
    rd_idx  = IDX_W'(a_int - RD_BASE);
  end

  // commit at the closing pulse
  always_comb begin
    we_a  = end_evt && len_ok && sel_q && (is_coef || is_pair);
    we_b  = end_evt && len_ok && sel_q && is_pair;
    sel_n = sel_q;
    if (end_evt && len_ok && is_sel)
      sel_n = (data_q[COEF_W-1:0] == COEF_W'(SEL_WORD));
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) sel_q <= 1'b0;
    else          sel_q <= sel_n;
  end

  cbus_regfile #(
    .N(COEF_N), .W(COEF_W), .RST_IDX(CTRL_IDX), .RST_VAL(CTRL_RST), .IW(IDX_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_i_n),
    .we_a(we_a), .ia(ia), .da(data_q[COEF_W-1:0]),
    .we_b(we_b), .ib(IDX_W'(1)), .db(data_q[DATA_W-1:COEF_W]),
    .ra(coef_idx), .qa(coef_q),
    .rb(rd_idx), .qb(rd_val)
  );

  // read-out path on the shared line
  always_comb begin
    rd_act_n = rd_act_q;
    drv_n    = drv_q;
    rd_sh_n  = rd_sh_q;
    if (end_evt || phase == PH_IDLE) begin
      rd_act_n = 1'b0;
      drv_n    = 1'b1;
    end else if (addr_done) begin
      rd_act_n = sel_q && is_rd;
      rd_sh_n  = rd_val;
      drv_n    = 1'b1;
    end else if (fl[1] && rd_act_q && phase == PH_DATA) begin
      drv_n = 1'b1;
      for (int i = 0; i < COEF_W; i++)
        if (cnt == CNT_W'(i)) drv_n = rd_sh_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      rd_act_q <= 1'b0;
      drv_q    <= 1'b1;
      rd_sh_q  <= '0;
    end else begin
      rd_act_q <= rd_act_n;
      drv_q    <= drv_n;
      rd_sh_q  <= rd_sh_n;
    end
  end

  assign cb_data_pull = rd_act_q && !drv_q;
endmodule

// File: rtl/cbus_slave_chk.sv
module cbus_slave_chk
  import cbus_pkg::*;
#(
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input phase_e        phase,
  input logic          end_evt,
  input logic          addr_done,
  input logic [CW-1:0] cnt,
  input logic          we_a,
  input logic          we_b,
  input logic          sel_q,
  input logic          rd_act_q,
  input logic          cb_data_pull
);
  // R12
  pull_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cb_data_pull |-> (phase == PH_DATA && rd_act_q));
  // R5
  write_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_a || we_b) |-> sel_q);
  // R3
  write_at_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_a || we_b) |-> end_evt);
  // R7
  pair_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_b |-> we_a);
  // R2
  addr_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_done |-> (cnt == CW'(8)));
  // R4
  sel_after_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_q) |-> $past(end_evt));
endmodule

bind cbus_slave cbus_slave_chk #(.CW(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_i_n), .phase(phase), .end_evt(end_evt),
  .addr_done(addr_done), .cnt(cnt), .we_a(we_a), .we_b(we_b),
  .sel_q(sel_q), .rd_act_q(rd_act_q), .cb_data_pull(cb_data_pull)
);

// File: tb/sim_cbus_slave.sv
module sim_cbus_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int NC         = 35;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       host_id, host_ck, host_d;
  logic       pull;
  logic [5:0] coef_idx;
  logic [7:0] coef_q;
  logic       line;
  int         n_run = 0, n_fail = 0;
  logic [7:0] exp_k [NC];
  bit         done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign line = host_d & ~pull;

  cbus_slave u0 (
    .clk(clk), .rst_n(rst_n), .cb_ident(host_id), .cb_clk(host_ck),
    .cb_data(line), .cb_data_pull(pull), .coef_idx(coef_idx), .coef_q(coef_q)
  );

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_addr(input int a, input int na);
    host_id = 1'b0;
    wait_cyc(HALF);
    for (int i = 0; i < na; i++) begin
      host_ck = 1'b0;
      host_d  = (i < 8) ? a[i] : 1'b0;
      wait_cyc(HALF);
      host_ck = 1'b1;
      wait_cyc(HALF);
    end
    host_d  = 1'b1;
    host_id = 1'b1;
    wait_cyc(HALF);
  endtask

  task automatic close_xfer();
    host_d = 1'b1;
    wait_cyc(HALF);
    host_id = 1'b0;
    wait_cyc(HALF);
    host_id = 1'b1;
    wait_cyc(2*HALF);
  endtask

  task automatic xfer(input int a, input logic [15:0] d, input int na,
                      input int nd, input int stall_at);
    send_addr(a, na);
    for (int i = 0; i < nd; i++) begin
      if (i == stall_at) wait_cyc(4000);
      host_ck = 1'b0;
      host_d  = d[i];
      wait_cyc(HALF);
      host_ck = 1'b1;
      wait_cyc(HALF);
    end
    close_xfer();
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    xfer(a, {8'h00, d}, 8, 8, -1);
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    send_addr(a, 8);
    for (int i = 0; i < 8; i++) begin
      host_ck = 1'b0;
      host_d  = 1'b1;
      wait_cyc(HALF);
      v[i] = line;
      host_ck = 1'b1;
      wait_cyc(HALF);
    end
    close_xfer();
  endtask

  task automatic verify_all(input string req);
    for (int i = 0; i < NC; i++) begin
      coef_idx = 6'(i);
      #1;
      check(req, {8'h00, coef_q}, {8'h00, exp_k[i]});
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    host_id = 1'b1; host_ck = 1'b1; host_d = 1'b1;
    coef_idx = '0;
    rst_n = 1'b0;
    for (int i = 0; i < NC; i++) exp_k[i] = (i == 33) ? 8'h08 : 8'h00;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(5);

    // R1 reset contents and released line
    verify_all("R1");
    check("R1 pull", {15'd0, pull}, 16'd0);

    // R5 writes while deselected are ignored, including the pair address
    wr(64, 8'h5A);
    xfer(100, 16'h1234, 8, 16, -1);
    verify_all("R5");
    // R9 read while deselected sees released line
    rd(128, rv);
    check("R9 deselected read", {8'h00, rv}, 16'h00FF);

    // R4 wrong select word keeps device deselected
    wr(102, 8'd14);
    wr(65, 8'h77);
    verify_all("R4 wrong select");
    // R4 correct select word enables writes
    wr(102, 8'd15);
    wr(64, 8'h33);
    exp_k[0] = 8'h33;
    verify_all("R4 select");

    // R6 sweep all mapped addresses; R11 read-out port
    for (int i = 0; i < NC; i++) begin
      logic [7:0] v;
      v = 8'((i * 37 + 11) ^ (i << 4));
      wr(64 + i, v);
      exp_k[i] = v;
    end
    verify_all("R6");
    coef_idx = 6'd40;
    #1;
    check("R11 out of range", {8'h00, coef_q}, 16'h0000);

    // R8 unmapped addresses
    wr(63, 8'hEE);
    wr(99, 8'hEE);
    wr(101, 8'hEE);
    wr(103, 8'hEE);
    wr(200, 8'hEE);
    verify_all("R8");

    // R7 16-bit pair write
    xfer(100, 16'hB7C4, 8, 16, -1);
    exp_k[0] = 8'hC4;
    exp_k[1] = 8'hB7;
    verify_all("R7");

    // R3 wrong lengths discarded
    xfer(70, 16'h00A5, 8, 7, -1);
    xfer(70, 16'hA5A5, 8, 16, -1);
    xfer(100, 16'h0099, 8, 8, -1);
    verify_all("R3");

    // R2 truncated address phase abandons transfer
    xfer(66, 16'h0042, 6, 8, -1);
    xfer(66, 16'h0042, 9, 8, -1);
    verify_all("R2");

    // R10 long stall mid data phase still commits
    xfer(90, 16'h005C, 8, 8, 4);
    exp_k[26] = 8'h5C;
    verify_all("R10");

    // R9 bus read of every coefficient; R12 line released afterwards
    for (int i = 0; i < NC; i++) begin
      logic [7:0] v;
      rd(128 + i, v);
      check("R9 read", {8'h00, v}, {8'h00, exp_k[i]});
    end
    check("R12 idle pull", {15'd0, pull}, 16'd0);
    rd(127, rv);
    check("R9 unmapped read", {8'h00, rv}, 16'h00FF);

    // R4 deselect with other value, then writes and reads are refused
    wr(102, 8'd0);
    wr(70, 8'h11);
    verify_all("R4 deselect");
    rd(130, rv);
    check("R12 deselected read", {8'h00, rv}, 16'h00FF);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule